// File: doc/BRIEF.md
# Multi-channel result register read sequencer

This block holds the results of one simultaneous-sampling conversion sequence in a small bank of result registers, four by default. It returns them one at a time over a parallel read bus. A read pointer picks the register that drives the bus. Each completed read strobe moves the pointer to the next channel of the sequence. When the last channel of the programmed sequence has been read, the pointer goes back to the first register.

The host may read before the sequence has finished. In that case the pointer never steps onto a register whose conversion has not landed yet. The advance is held as pending and is carried out on the same clock edge that stores that channel's result. The host can therefore use the conversion-done timing to pace its reads.

A sequence-start pulse clears every valid mark, sends the pointer home and latches the sequence length. A first-data flag shows when the pointer is on the first register.

Top module: `result_read_seq`

## Requirements
- R1: After reset the pointer is on register 1 (index 0), first_data is 1, data_oe is 0 and data_out is all zeros.
- R2: data_oe is 1 and data_out carries the addressed register only while cs_n and rd_n are both 0, in the same cycle. Otherwise data_oe is 0 and data_out is all zeros.
- R3: A conv_done pulse stores conv_data into the register indexed by conv_chan (0 = register 1) and marks that register valid on the same clock edge. A pulse that arrives together with seq_start is dropped.
- R4: A read edge is a cycle in which rd_n is 1, rd_n was 0 in the previous cycle, and cs_n is 0. A rising rd_n while cs_n is 1 leaves the pointer unchanged.
- R5: While busy is 0, each read edge moves the pointer one register forward at that clock edge.
- R6: On the read edge that leaves the last register of the latched length, the pointer returns to register 1.
- R7: While busy is 1, a read edge whose target register is not valid leaves the pointer in place and records a pending advance. The pointer then steps on the clock edge that accepts the conv_done for that register, or on the first edge at which busy is 0, whichever comes first. Further read edges are ignored while an advance is pending.
- R8: seq_start clears all valid marks and any pending advance, puts the pointer on register 1, and latches seq_len. A value of 0 is taken as 1, and a value above the register count is taken as the register count.
- R9: With a latched length of 1, read edges never move the pointer off register 1.
- R10: first_data is 1 exactly when the pointer is on register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_start | input | 1 | Pulse that begins a new conversion sequence |
| seq_len | input | 3 | Number of channels in the sequence, latched at seq_start |
| busy | input | 1 | High while the sequence is still converting |
| conv_done | input | 1 | One-cycle pulse: a channel result is ready |
| conv_chan | input | 2 | Channel index of the result that is ready |
| conv_data | input | 12 | Result value that is ready |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| data_out | output | 12 | Read data, zero when not enabled |
| data_oe | output | 1 | Read data enable |
| first_data | output | 1 | Pointer is on register 1 |

## Verification
Bus enable and bus data follow cs_n and rd_n in the same cycle, so the bench checks them one nanosecond after it drives the strobes low. Pointer moves, stored results and first_data become visible after exactly one rising edge: the edge on which rd_n is first seen high, or the edge that accepts conv_done. A deferred advance lands on the edge that accepts conv_done for its target register. The bench drives every input on the falling clock edge and samples just after the following falling edge, so each expected value is compared one register stage after its cause.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    // Index that follows idx in a sequence of len registers; wraps to 0.
    function automatic int unsigned rrs_next_idx(input int unsigned idx,
                                                 input int unsigned len);
        return ((idx + 1) >= len) ? 0 : idx + 1;
    endfunction

    // Legal sequence length: 0 is read as 1, excess is clipped to maxlen.
    function automatic int unsigned rrs_clamp_len(input int unsigned raw,
                                                  input int unsigned maxlen);
        if (raw == 0)
            return 1;
        else if (raw > maxlen)
            return maxlen;
        else
            return raw;
    endfunction

endpackage

// File: rtl/rrs_read_strobe.sv
module rrs_read_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    output logic rd_edge
);
    typedef struct packed {
        logic rd_prev;
    } strobe_state_t;

    strobe_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.rd_prev = rd_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{rd_prev: 1'b1};
        else
            s_q <= s_d;
    end

    // Release of the strobe while the chip is selected
    assign rd_edge = rd_n & ~s_q.rd_prev & ~cs_n;

    AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_edge |=> !rd_edge); // R4

endmodule

// File: rtl/rrs_result_bank.sv
module rrs_result_bank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 12,
    localparam int PTR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seq_start,
    input  logic                conv_done,
    input  logic [PTR_W-1:0]    conv_chan,
    input  logic [DATA_W-1:0]   conv_data,
    input  logic [PTR_W-1:0]    sel_idx,
    output logic [NUM_REGS-1:0] valid_q,
    output logic [NUM_REGS-1:0] valid_now,
    output logic [DATA_W-1:0]   sel_data
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [NUM_REGS-1:0]             valid;
    } bank_state_t;

    bank_state_t        s_d, s_q;
    logic               wr_ok;
    logic [NUM_REGS-1:0] wr_hit;

    assign wr_ok = conv_done & ~seq_start;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
            assign wr_hit[g] = wr_ok && (conv_chan == PTR_W'(g));
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (seq_start) begin
            s_d.valid = '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_hit[i]) begin
                    s_d.regs[i]  = conv_data;
                    s_d.valid[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign valid_q   = s_q.valid;
    // Valid marks including a result arriving on this edge
    assign valid_now = seq_start ? '0 : (s_q.valid | wr_hit);
    assign sel_data  = s_q.regs[sel_idx];

    AST_START_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_start) |-> (valid_q == '0)); // R8

    AST_DONE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(conv_done && !seq_start) |-> valid_q[$past(conv_chan)]); // R3

endmodule

// File: rtl/rrs_pointer.sv
module rrs_pointer #(
    parameter int NUM_REGS = 4,
    localparam int PTR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int LEN_W   = $clog2(NUM_REGS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seq_start,
    input  logic [LEN_W-1:0]    seq_len,
    input  logic                busy,
    input  logic                rd_edge,
    input  logic [NUM_REGS-1:0] valid_now,
    input  logic [NUM_REGS-1:0] valid_q,
    output logic [PTR_W-1:0]    ptr,
    output logic [LEN_W-1:0]    len
);
    import rrs_pkg::*;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [LEN_W-1:0] len;
        logic             pending;
    } ptr_state_t;

    ptr_state_t       s_d, s_q;
    logic [PTR_W-1:0] tgt;
    logic             tgt_ready;

    assign tgt       = PTR_W'(rrs_next_idx(32'(s_q.ptr), 32'(s_q.len)));
    assign tgt_ready = !busy || valid_now[tgt];

    always_comb begin
        s_d = s_q;
        if (seq_start) begin
            s_d.ptr     = '0;
            s_d.pending = 1'b0;
            s_d.len     = LEN_W'(rrs_clamp_len(32'(seq_len), NUM_REGS));
        end else if (s_q.pending) begin
            if (tgt_ready) begin
                s_d.ptr     = tgt;
                s_d.pending = 1'b0;
            end
        end else if (rd_edge) begin
            if (tgt_ready)
                s_d.ptr = tgt;
            else
                s_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{ptr: '0, len: LEN_W'(NUM_REGS), pending: 1'b0};
        else
            s_q <= s_d;
    end

    assign ptr = s_q.ptr;
    assign len = s_q.len;

    AST_START_HOMES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(seq_start) |-> (ptr == '0 && !s_q.pending)); // R8

    AST_NO_STEP_TO_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) && $past(busy) && !$past(seq_start) |-> valid_q[ptr]); // R7

    AST_PEND_WAITS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pending |-> !valid_q[tgt]); // R7

    AST_PTR_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr) < 32'(len)); // R6

endmodule

// File: rtl/result_read_seq.sv
module result_read_seq #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 12,
    localparam int PTR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int LEN_W   = $clog2(NUM_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_start,
    input  logic [LEN_W-1:0]  seq_len,
    input  logic              busy,
    input  logic              conv_done,
    input  logic [PTR_W-1:0]  conv_chan,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              first_data
);
    logic                rd_edge;
    logic [NUM_REGS-1:0] valid_q;
    logic [NUM_REGS-1:0] valid_now;
    logic [PTR_W-1:0]    ptr;
    logic [LEN_W-1:0]    len;
    logic [DATA_W-1:0]   sel_data;

    rrs_read_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .rd_edge (rd_edge)
    );

    rrs_result_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_start (seq_start),
        .conv_done (conv_done),
        .conv_chan (conv_chan),
        .conv_data (conv_data),
        .sel_idx   (ptr),
        .valid_q   (valid_q),
        .valid_now (valid_now),
        .sel_data  (sel_data)
    );

    rrs_pointer #(
        .NUM_REGS (NUM_REGS)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .seq_start (seq_start),
        .seq_len   (seq_len),
        .busy      (busy),
        .rd_edge   (rd_edge),
        .valid_now (valid_now),
        .valid_q   (valid_q),
        .ptr       (ptr),
        .len       (len)
    );

    // Drivers are enabled only while both strobes are low
    assign data_oe    = ~cs_n & ~rd_n;
    assign data_out   = data_oe ? sel_data : '0;
    assign first_data = (ptr == '0);

    AST_LEN_ONE_STAYS_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (len == LEN_W'(1)) && !$past(seq_start) |-> first_data); // R9

endmodule

// File: tb/result_read_seq_bench.sv
module result_read_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seq_start = 1'b0;
    logic [2:0]  seq_len = 3'd4;
    logic        busy = 1'b0;
    logic        conv_done = 1'b0;
    logic [1:0]  conv_chan = 2'd0;
    logic [11:0] conv_data = 12'd0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [11:0] data_out;
    logic        data_oe;
    logic        first_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    result_read_seq u_result_read_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_start  (seq_start),
        .seq_len    (seq_len),
        .busy       (busy),
        .conv_done  (conv_done),
        .conv_chan  (conv_chan),
        .conv_data  (conv_data),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .data_out   (data_out),
        .data_oe    (data_oe),
        .first_data (first_data)
    );

    // {len[50:48], ch3[47:36], ch2[35:24], ch1[23:12], ch0[11:0]}
    localparam logic [50:0] VECS [0:3] = '{
        {3'd4, 12'hFFF, 12'h001, 12'h3F0, 12'hA5C},
        {3'd3, 12'hABC, 12'h789, 12'h456, 12'h123},
        {3'd2, 12'h000, 12'h000, 12'h7FF, 12'h800},
        {3'd1, 12'h000, 12'h000, 12'h000, 12'h5A5}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic start_seq(input logic [2:0] len);
        @(negedge clk);
        seq_start = 1'b1;
        seq_len   = len;
        @(negedge clk);
        seq_start = 1'b0;
    endtask

    task automatic convert(input logic [1:0] ch, input logic [11:0] d);
        @(negedge clk);
        conv_done = 1'b1;
        conv_chan = ch;
        conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // One full read strobe; checks the bus while enabled
    task automatic read_one(input string req, input logic [11:0] exp_d,
                            input logic exp_first);
        @(negedge clk);
        cs_n = 1'b0;
        rd_n = 1'b0;
        #1;
        check({req, " data"}, int'(data_out), int'(exp_d));
        check("R2 oe", int'(data_oe), 1);
        check({"R10 first ", req}, int'(first_data), int'(exp_first));
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int len;
        logic [11:0] dv [4];
        repeat (3) @(negedge clk);
        #1;
        check("R1 first_data", int'(first_data), 1);
        check("R1 oe", int'(data_oe), 0);
        check("R1 data", int'(data_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: fill each sequence, then read past the wrap
        for (int v = 0; v < 4; v++) begin
            len = int'(VECS[v][50:48]);
            for (int c = 0; c < 4; c++) dv[c] = VECS[v][c*12 +: 12];
            start_seq(VECS[v][50:48]);
            check("R8 home", int'(first_data), 1);
            busy = 1'b1;
            for (int c = 0; c < len; c++) convert(2'(c), dv[c]);
            busy = 1'b0;
            for (int r = 0; r <= len; r++)
                read_one("R5 R6 R3", dv[r % len], (r % len) == 0);
        end

        // R2: only one strobe low keeps the bus released
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b1; #1;
        check("R2 cs only oe", int'(data_oe), 0);
        check("R2 cs only data", int'(data_out), 0);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        check("R2 rd only oe", int'(data_oe), 0);
        check("R2 rd only data", int'(data_out), 0);
        @(negedge clk);
        rd_n = 1'b1;

        // R4: rd_n rising while deselected does not move the pointer
        start_seq(3'd4);
        convert(2'd0, 12'h0C3);
        convert(2'd1, 12'h13C);
        @(negedge clk); rd_n = 1'b0;
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk); #1;
        check("R4 unselected edge", int'(first_data), 1);
        read_one("R4 data", 12'h0C3, 1'b1);
        check("R5 moved", int'(first_data), 0);

        // R8: restart mid-sequence returns home
        start_seq(3'd4);
        check("R8 restart home", int'(first_data), 1);

        // R7: read ahead of the conversions
        busy = 1'b1;
        convert(2'd0, 12'h111);
        read_one("R7 first", 12'h111, 1'b1);
        check("R7 held", int'(first_data), 1);
        read_one("R7 ignored edge", 12'h111, 1'b1);
        convert(2'd1, 12'h222);
        check("R7 stepped on done", int'(first_data), 0);
        read_one("R7 second", 12'h222, 1'b0);
        convert(2'd2, 12'h333);
        convert(2'd3, 12'h444);
        busy = 1'b0;
        read_one("R7 third", 12'h333, 1'b0);

        // R8 + R9: length 0 is taken as 1, pointer stays home
        start_seq(3'd0);
        convert(2'd0, 12'h0AA);
        read_one("R9 len0 a", 12'h0AA, 1'b1);
        read_one("R9 len0 b", 12'h0AA, 1'b1);
        check("R9 home", int'(first_data), 1);

        // R8: length 7 is clipped to 4
        start_seq(3'd7);
        for (int c = 0; c < 4; c++) convert(2'(c), 12'(12'h900 + c));
        for (int r = 0; r <= 4; r++)
            read_one("R8 clip", 12'(12'h900 + (r % 4)), (r % 4) == 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule